// File: doc/BRIEF.md
# Serial Flash Wake-and-Signature Responder

This block is the slave-side front end of a serial flash device that understands exactly one command: the legacy wake-up / electronic-signature request, opcode 8'hAB. A fast system clock oversamples the chip select, serial clock and serial data-in pins. After the opcode and three dummy bytes, the block streams a one-byte device identifier on a tri-stateable serial output. The identifier repeats for as long as the host keeps clocking with chip select low.

The same opcode also takes the device out of deep power-down. Once the opcode has been accepted in the power-down state, the rising edge of chip select starts a wake-up window of a fixed number of system clocks. Until that window has elapsed, further requests are rejected. When the command arrives while the program/erase engine reports busy, it is ignored completely. Power-down is entered through a dedicated input, and a status output stays high while the device is asleep or waking.

The command FSM has these states: IDLE (deselected), OPCODE (shifting in the command byte), DUMMY (24 ignored clocks), STREAM (driving the ID) and IGNORE (rejected until deselect). Its transitions are:
- IDLE→OPCODE when selected.
- OPCODE→DUMMY when the eighth bit completes a match and the engine is neither busy nor waking.
- OPCODE→IGNORE when the eighth bit completes in any other case.
- DUMMY→STREAM after the 24th dummy clock.
- Any state→IDLE on deselect.

The power FSM has these states: AWAKE, ASLEEP and WAKING. Its transitions are:
- AWAKE→ASLEEP on the power-down input.
- ASLEEP→WAKING on a release strobe issued at deselect after an accepted opcode.
- WAKING→AWAKE when the timer expires.

Top module: `flash_sig_responder`

## Requirements
- R1: After reset the output enable is low and the power status output is low (awake).
- R2: The block works in both clock-idle-low (mode 0) and clock-idle-high (mode 3) operation. Input bits are taken on serial-clock rising edges. Each output bit changes after a falling edge and is stable before the next rising edge.
- R3: The only accepted opcode is 8'hAB, sent MSB first. Any other opcode leaves the output disabled for the whole selection.
- R4: The output enable stays low during the 8 opcode clocks and the 24 dummy clocks, whatever data is on the input during the dummy clocks.
- R5: After the dummy clocks, the ID byte 8'h12 is sent MSB first, with the first bit following the 32nd falling edge's predecessor rising edge. It repeats back to back with no gap.
- R6: Chip select going high turns the output enable off within 3 system clocks.
- R7: An opcode that completes while the busy input is 1 is ignored: no output is driven and the power state does not change.
- R8: A pulse on the power-down input while awake sets the status output high.
- R9: In power-down, an accepted opcode still streams the ID. Deselecting then starts a wake window of WAKE_CYCLES system clocks. The status output stays high through the window and goes low once it has elapsed.
- R10: A request made during the wake window is rejected (no output), and it does not restart the window.
- R11: A selection that ends partway through a byte is discarded. The next selection counts bits from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| busy_in | input | 1 | Program/erase engine busy |
| pd_enter | input | 1 | Single-cycle request to enter power-down |
| spi_miso | output | 1 | Serial data out value |
| spi_miso_oe | output | 1 | Serial data out enable (low means high impedance) |
| pd_status | output | 1 | High while asleep or waking |

## Verification
A bit counter that is off by one shows at the ports as an ID stream rotated by one bit, or as output starting a clock early, within the first streamed byte. A wrong power state shows up as the status output failing to drop about WAKE_CYCLES clocks after deselect, or as an ID being streamed in the middle of the wake window. A busy or opcode check that leaks shows up at once as an enabled output on a selection that should stay silent. Selections in both clock modes, with truncated bytes and with varying dummy data, expose these faults within one selection.

// File: rtl/sig_pkg.sv
package sig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_DUMMY,
        ST_STREAM,
        ST_IGNORE
    } cmd_state_t;

    typedef enum logic [1:0] {
        PW_AWAKE,
        PW_ASLEEP,
        PW_WAKING
    } pwr_state_t;

    localparam int CMD_BITS = 8;

endpackage

// File: rtl/sig_pin_sync.sv
module sig_pin_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RESET_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= pin_in;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/sig_edge_det.sv
module sig_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

endmodule

// File: rtl/sig_cmd_fsm.sv
module sig_cmd_fsm
    import sig_pkg::*;
#(
    parameter logic [7:0] CMD_CODE   = 8'hAB,
    parameter logic [7:0] DEV_ID     = 8'h12,
    parameter int         DUMMY_BITS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic sck_lvl,
    input  logic sck_rise,
    input  logic sck_fall,
    input  logic mosi,
    input  logic busy,
    input  logic waking,
    output logic miso_q,
    output logic miso_oe,
    output logic release_stb
);

    localparam int CNT_MAX = (DUMMY_BITS > CMD_BITS) ? DUMMY_BITS : CMD_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] OP_LAST    = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_BITS - 1);

    cmd_state_t           state_q, state_d;
    logic [CNT_W-1:0]     bit_cnt;
    logic [CMD_BITS-2:0]  op_shreg;
    logic [2:0]           out_idx;
    logic                 edge_ok;
    logic                 release_pend;
    logic                 opcode_hit;
    logic                 drive_bit;

    assign opcode_hit = ({op_shreg, mosi} == CMD_CODE);
    assign drive_bit  = (state_q == ST_STREAM) && sck_fall && edge_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_act) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (sck_rise && bit_cnt == OP_LAST) begin
                    state_d = (opcode_hit && !busy && !waking) ? ST_DUMMY : ST_IGNORE;
                end
            end
            ST_DUMMY: begin
                if (sck_rise && bit_cnt == DUMMY_LAST) state_d = ST_STREAM;
            end
            ST_STREAM: state_d = ST_STREAM;
            ST_IGNORE: state_d = ST_IGNORE;
            default:   state_d = ST_IDLE;
        endcase
        if (!cs_act) state_d = ST_IDLE;
    end

    // Bit counting and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            op_shreg     <= '0;
            out_idx      <= 3'd7;
            edge_ok      <= 1'b0;
            release_pend <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            bit_cnt      <= '0;
            out_idx      <= 3'd7;
            release_pend <= 1'b0;
            // mode 0 idles low: a falling edge is valid at once; mode 3 waits for a rise
            edge_ok      <= ~sck_lvl;
        end else begin
            if (state_d != state_q) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (sck_rise) begin
                edge_ok  <= 1'b1;
                op_shreg <= {op_shreg[CMD_BITS-3:0], mosi};
            end
            if (state_q == ST_OPCODE && state_d == ST_DUMMY) begin
                release_pend <= 1'b1;
            end
            if (drive_bit) begin
                out_idx <= out_idx - 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_q      <= 1'b0;
            miso_oe     <= 1'b0;
            release_stb <= 1'b0;
        end else begin
            release_stb <= (state_q != ST_IDLE) && !cs_act && release_pend;
            if (!cs_act) begin
                miso_q  <= 1'b0;
                miso_oe <= 1'b0;
            end else if (drive_bit) begin
                miso_q  <= DEV_ID[out_idx];
                miso_oe <= 1'b1;
            end
        end
    end

    // R6: deselect disables the output on the next clock
    a_r6_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_oe);

    // R4: the output is enabled only in the streaming phase
    a_r4_oe_only_stream: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> (state_q == ST_STREAM));

    // R7: a busy engine forces the rejection path
    a_r7_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && state_q == ST_OPCODE && sck_rise && bit_cnt == OP_LAST && busy)
        |=> (state_q == ST_IGNORE));

    // R10: a request during the wake window is rejected
    a_r10_wake_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && state_q == ST_OPCODE && sck_rise && bit_cnt == OP_LAST && waking)
        |=> (state_q == ST_IGNORE));

    // R3: a rejected selection never reaches the release strobe
    a_r3_ignore_no_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !release_pend);

endmodule

// File: rtl/sig_power_ctrl.sv
module sig_power_ctrl
    import sig_pkg::*;
#(
    parameter int WAKE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_enter,
    input  logic release_stb,
    output logic waking,
    output logic pd_status
);

    localparam int TMR_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WAKE_CYCLES - 1);

    pwr_state_t       pstate_q, pstate_d;
    logic [TMR_W-1:0] tmr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pstate_q <= PW_AWAKE;
        end else begin
            pstate_q <= pstate_d;
        end
    end

    // Next-state logic
    always_comb begin
        pstate_d = pstate_q;
        unique case (pstate_q)
            PW_AWAKE:  if (pd_enter)          pstate_d = PW_ASLEEP;
            PW_ASLEEP: if (release_stb)       pstate_d = PW_WAKING;
            PW_WAKING: if (tmr_q == TMR_LAST) pstate_d = PW_AWAKE;
            default:                          pstate_d = PW_AWAKE;
        endcase
    end

    // Wake timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (pstate_q != PW_WAKING) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        waking    = (pstate_q == PW_WAKING);
        pd_status = (pstate_q != PW_AWAKE);
    end

    // R8: power-down request while awake raises the status
    a_r8_enter_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_enter && pstate_q == PW_AWAKE) |=> pd_status);

    // R9: wake window starts only from a release strobe
    a_r9_wake_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate_q == PW_ASLEEP && !release_stb) |=> (pstate_q != PW_WAKING));

    // R9: the timer never passes its limit
    a_r9_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        waking |-> (tmr_q < TMR_W'(WAKE_CYCLES)));

    // R10: strobes during the window do not restart the timer
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (waking && tmr_q != TMR_LAST) |=> (tmr_q == $past(tmr_q) + 1'b1));

endmodule

// File: rtl/flash_sig_responder.sv
module flash_sig_responder #(
    parameter logic [7:0] CMD_CODE    = 8'hAB,
    parameter logic [7:0] DEV_ID      = 8'h12,
    parameter int         DUMMY_BITS  = 24,
    parameter int         WAKE_CYCLES = 200,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic busy_in,
    input  logic pd_enter,
    output logic spi_miso,
    output logic spi_miso_oe,
    output logic pd_status
);

    logic [2:0] pins_sync;
    logic       csn_s, sck_s, mosi_s;
    logic       sck_rise, sck_fall;
    logic       release_stb;
    logic       waking;

    sig_pin_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({spi_csn, spi_sck, spi_mosi}),
        .pin_sync (pins_sync)
    );

    assign {csn_s, sck_s, mosi_s} = pins_sync;

    sig_edge_det u_sck_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sck_s),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    sig_cmd_fsm #(
        .CMD_CODE   (CMD_CODE),
        .DEV_ID     (DEV_ID),
        .DUMMY_BITS (DUMMY_BITS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act      (~csn_s),
        .sck_lvl     (sck_s),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .mosi        (mosi_s),
        .busy        (busy_in),
        .waking      (waking),
        .miso_q      (spi_miso),
        .miso_oe     (spi_miso_oe),
        .release_stb (release_stb)
    );

    sig_power_ctrl #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_enter    (pd_enter),
        .release_stb (release_stb),
        .waking      (waking),
        .pd_status   (pd_status)
    );

endmodule

// File: tb/tb_flash_sig_responder.sv
`timescale 1ns/1ps
module tb_flash_sig_responder;

    localparam int WAKE = 1000;
    localparam int HALF = 6;
    localparam logic [7:0] ID = 8'h12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic busy_in = 1'b0, pd_enter = 1'b0;
    logic spi_miso, spi_miso_oe, pd_status;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int oe_early, oe_missing, oe_after_cs, t_csrise;
    logic [7:0] rx [4];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_sig_responder #(.WAKE_CYCLES(WAKE)) dut (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .busy_in(busy_in), .pd_enter(pd_enter),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .pd_status(pd_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // One selection: opcode then dummy data, sampling the output before each rising edge
    task automatic frame(input bit mode3, input logic [7:0] op, input int nbits);
        oe_early = 0; oe_missing = 0;
        for (int k = 0; k < 4; k++) rx[k] = 8'h00;
        spi_sck = mode3;
        clocks(4);
        spi_csn = 1'b0;
        clocks(4);
        for (int i = 0; i < nbits; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = (i < 8) ? op[7-i] : ((i % 3) == 0);
            clocks(HALF);
            if (i < 32) begin
                if (spi_miso_oe) oe_early++;
            end else begin
                if (!spi_miso_oe) oe_missing++;
                rx[(i-32)/8][7-((i-32)%8)] = spi_miso;
            end
            spi_sck = 1'b1;
            clocks(HALF);
        end
        if (!mode3) spi_sck = 1'b0;
        clocks(HALF);
        spi_csn = 1'b1;
        t_csrise = cyc;
        clocks(4);
        oe_after_cs = int'(spi_miso_oe);
        clocks(4);
    endtask

    task automatic t_reset;
        check("R1 oe after reset", spi_miso_oe, 0);
        check("R1 status after reset", pd_status, 0);
    endtask

    task automatic t_mode0;
        frame(0, 8'hAB, 32 + 24);
        check("R4 oe during opcode/dummy", oe_early, 0);
        check("R2 R5 mode0 byte0", rx[0], ID);
        check("R5 repeat byte1", rx[1], ID);
        check("R5 repeat byte2", rx[2], ID);
        check("R5 oe held while streaming", oe_missing, 0);
        check("R6 hiz after deselect", oe_after_cs, 0);
        check("R9 awake request leaves status low", pd_status, 0);
    endtask

    task automatic t_mode3;
        frame(1, 8'hAB, 32 + 16);
        check("R4 mode3 oe during opcode/dummy", oe_early, 0);
        check("R2 mode3 byte0", rx[0], ID);
        check("R2 mode3 byte1", rx[1], ID);
        check("R6 mode3 hiz after deselect", oe_after_cs, 0);
    endtask

    task automatic t_bad_opcode;
        frame(0, 8'h9F, 48);
        check("R3 opcode 9F silent early", oe_early, 0);
        check("R3 opcode 9F silent stream", oe_missing, 16);
        frame(1, 8'hAA, 48);
        check("R3 opcode AA silent", oe_early + (16 - oe_missing), 0);
    endtask

    task automatic t_busy;
        pd_enter = 1'b1; clocks(1); pd_enter = 1'b0; clocks(2);
        check("R8 status after power-down", pd_status, 1);
        busy_in = 1'b1;
        frame(0, 8'hAB, 48);
        check("R7 busy no output", oe_early + (16 - oe_missing), 0);
        clocks(WAKE + 50);
        check("R7 busy no wake", pd_status, 1);
        busy_in = 1'b0;
    endtask

    task automatic t_wake;
        int t0;
        frame(0, 8'hAB, 40);
        t0 = t_csrise;
        check("R9 ID streamed from power-down", rx[0], ID);
        check("R9 status high in window", pd_status, 1);
        frame(0, 8'hAB, 48);
        check("R10 request during wake silent", oe_early + (16 - oe_missing), 0);
        while (cyc < t0 + WAKE - 30) clocks(1);
        check("R9 status high before expiry", pd_status, 1);
        while (cyc < t0 + WAKE + 30) clocks(1);
        check("R10 window not restarted", pd_status, 0);
        frame(0, 8'hAB, 40);
        check("R9 accepted after wake", rx[0], ID);
    endtask

    task automatic t_partial;
        frame(0, 8'hAB, 5);
        check("R11 truncated selection silent", oe_early, 0);
        frame(1, 8'hAB, 40);
        check("R11 fresh count after truncation", rx[0], ID);
    endtask

    initial begin
        clocks(5);
        rst_n = 1'b1;
        clocks(3);
        t_reset();
        t_mode0();
        t_mode3();
        t_bad_opcode();
        t_partial();
        t_busy();
        t_wake();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule